// File: doc/BRIEF.md
# ADC Configuration and Status Register Block

This block holds the configuration that a host sets for a multichannel analog-to-digital converter, and it produces the status word the host reads back. The host presents a 16-bit write word. The top two bits are an address and the low fourteen bits are a payload. The payload is stored in the control register only when the address is `2'b11`. The stored fields drive the converter's input mux, power and interface settings directly. Two of the fields also launch work in neighbouring engines: one launches a conversion and one launches a calibration.

The conversion-start bit and the calibration-start bit stay set while their engine works. Each one clears only when that engine returns its done strobe. The interface-mode bit clears at the end of every read cycle. A read request returns, one cycle later, a 16-bit word and a one-cycle done strobe. That word is the status view when the stored read-select field is `2'b11`. The status view echoes the configuration and adds the live busy indications.

Top module: `adcfg_regfile`

## Requirements
- R1: A write changes the stored configuration only when `wr_en` is high and `wr_word[15:14]` is `2'b11`. The payload layout, MSB first, is: bit 13 single-ended select; bits 12:10 channel; bits 9:8 power mode; bits 7:6 read select; bit 5 interface mode; bit 4 conversion start; bit 3 calibration mode; bits 2:1 calibration select; bit 0 calibration start.
- R2: After reset, every stored bit, every output word, every pulse and every flag is 0.
- R3: The status word is laid out as follows. Bit 15 is 0 and bit 4 is 0. Bits 13:5 echo stored payload bits 13:5, and bits 3:1 echo stored payload bits 3:1.
- R4: A write that sets bit 4 while no conversion is running raises `conv_go` for exactly the one cycle after the write. Stored bit 4 then stays 1 until `conv_done` is sampled high.
- R5: A start request made while the same engine is running produces no pulse. A write with the start bit 0 does not clear a running start bit.
- R6: A write that sets bit 0 while no calibration is running raises `cal_go` for exactly one cycle, and `cal_type` shows {bit 3, bits 2:1}. Stored bit 0 and status bit 0 stay 1 until `cal_done` is sampled high.
- R7: The interface-mode bit is 0 after every accepted read. If a control write arrives in the same cycle as the read, the written value is kept.
- R8: The cycle after `rd_en` is sampled high, `rd_done` is high for one cycle and `rd_data` carries the word. `rd_data` holds that word until the next read.
- R9: The read word is the status word only when stored bits 7:6 are `2'b11`. Otherwise `rd_data` is 0.
- R10: `coef_addr` always equals stored bits 2:1. `coef_ok` is 1 exactly when no calibration is running.
- R11: Status bit 14 and `busy` are 1 while a conversion or a calibration is running. A done strobe from an idle engine changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write word valid |
| wr_word | input | 16 | Address in [15:14], payload in [13:0] |
| rd_en | input | 1 | Read cycle request |
| conv_done | input | 1 | Conversion engine finished |
| cal_done | input | 1 | Calibration engine finished |
| cfg_single | output | 1 | Single-ended (1) or pseudo-differential (0) |
| cfg_chan | output | 3 | Channel select |
| cfg_pwr | output | 2 | Power management field |
| if_mode | output | 1 | Interface mode bit |
| conv_go | output | 1 | One-cycle conversion launch |
| cal_go | output | 1 | One-cycle calibration launch |
| cal_type | output | 3 | Calibration mode and select |
| coef_addr | output | 2 | Coefficient register address |
| coef_ok | output | 1 | Coefficient access allowed (no calibration running) |
| busy | output | 1 | Conversion or calibration running |
| rd_data | output | 16 | Read word |
| rd_done | output | 1 | End-of-read strobe |

## Verification
The bench first sends writes to the wrong address. These show whether the address decode protects the stored fields, and a read then confirms that a non-status selection returns zeros. A full configuration write followed by a read shows that every status field lands in its own bit position and that the mode bit clears afterwards. Start writes are then sent to an idle engine, to a running engine, and with the start bit dropped. This separates a genuine launch from a repeated request and from an attempted cancel. Done strobes are sent both while an engine runs and while it is idle, and a write and a read are issued in the same cycle to show which event owns the mode bit.

// File: rtl/adcfg_pkg.sv
package adcfg_pkg;
    localparam int WORD_W = 16;
    localparam int ADDR_W = 2;
    localparam int CH_W   = 3;
    localparam int PM_W   = 2;
    localparam int RS_W   = 2;
    localparam int CS_W   = 2;
    localparam int PAY_W  = 1 + CH_W + PM_W + RS_W + 1 + 1 + 1 + CS_W + 1;

    // Field order is fixed: the status word and the host both decode it.
    typedef struct packed {
        logic            single;
        logic [CH_W-1:0] chan;
        logic [PM_W-1:0] pwr;
        logic [RS_W-1:0] rsel;
        logic            mode;
        logic            conv;
        logic            calmd;
        logic [CS_W-1:0] csel;
        logic            stcal;
    } ctl_t;
endpackage

// File: rtl/adcfg_ctl.sv
module adcfg_ctl
    import adcfg_pkg::*;
#(
    parameter int             AW       = ADDR_W,
    parameter logic [AW-1:0]  CTL_ADDR = '1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  ctl_t          wr_pay,
    input  logic          rd_en,
    input  logic          conv_done,
    input  logic          cal_done,
    output ctl_t          ctl,
    output logic          conv_go,
    output logic          cal_go
);
    typedef struct packed {
        ctl_t ctl;
        logic conv_go;
        logic cal_go;
    } st_t;

    st_t  s_d, s_q;
    logic hit;

    assign hit = wr_en && (wr_addr == CTL_ADDR);

    always_comb begin
        s_d         = s_q;
        s_d.conv_go = 1'b0;
        s_d.cal_go  = 1'b0;
        if (rd_en)     s_d.ctl.mode  = 1'b0;
        if (conv_done) s_d.ctl.conv  = 1'b0;
        if (cal_done)  s_d.ctl.stcal = 1'b0;
        if (hit) begin
            s_d.ctl.single = wr_pay.single;
            s_d.ctl.chan   = wr_pay.chan;
            s_d.ctl.pwr    = wr_pay.pwr;
            s_d.ctl.rsel   = wr_pay.rsel;
            s_d.ctl.mode   = wr_pay.mode;
            s_d.ctl.calmd  = wr_pay.calmd;
            s_d.ctl.csel   = wr_pay.csel;
            if (wr_pay.conv && !s_q.ctl.conv) begin
                s_d.ctl.conv = 1'b1;
                s_d.conv_go  = 1'b1;
            end
            if (wr_pay.stcal && !s_q.ctl.stcal) begin
                s_d.ctl.stcal = 1'b1;
                s_d.cal_go    = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ctl     = s_q.ctl;
    assign conv_go = s_q.conv_go;
    assign cal_go  = s_q.cal_go;

    AST_CONV_GO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        conv_go |=> !conv_go); // R4
    AST_CONV_HELD_UNTIL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.conv && !conv_done) |=> ctl.conv); // R4
    AST_CONV_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done |=> !ctl.conv); // R4
    AST_NO_GO_WHILE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.conv |=> !conv_go); // R5
    AST_CAL_GO_SETS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        cal_go |-> ctl.stcal); // R6
    AST_MODE_READ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !hit) |=> !ctl.mode); // R7
    AST_NO_HIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> ($stable(ctl.chan) && $stable(ctl.pwr) && $stable(ctl.rsel))); // R1
endmodule

// File: rtl/adcfg_rdport.sv
module adcfg_rdport
    import adcfg_pkg::*;
#(
    parameter int              W          = WORD_W,
    parameter logic [RS_W-1:0] STATUS_SEL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  ctl_t         ctl,
    input  logic         rd_en,
    output logic [W-1:0] rd_data,
    output logic         rd_done
);
    typedef struct packed {
        logic [W-1:0] data;
        logic         done;
    } st_t;

    st_t          s_d, s_q;
    logic [W-1:0] stat_word;

    always_comb begin
        stat_word = {1'b0, ctl.conv | ctl.stcal, ctl.single, ctl.chan, ctl.pwr,
                     ctl.rsel, ctl.mode, 1'b0, ctl.calmd, ctl.csel, ctl.stcal};
        s_d      = s_q;
        s_d.done = rd_en;
        if (rd_en) s_d.data = (ctl.rsel == STATUS_SEL) ? stat_word : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rd_data = s_q.data;
    assign rd_done = s_q.done;

    AST_DONE_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_done); // R8
    AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data)); // R8
    AST_CAL_RUN_SHOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && ctl.stcal && ctl.rsel == STATUS_SEL) |=> (rd_data[0] && rd_data[14])); // R6
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |-> (!rd_data[W-1] && !rd_data[4])); // R3
endmodule

// File: rtl/adcfg_regfile.sv
module adcfg_regfile
    import adcfg_pkg::*;
#(
    parameter logic [ADDR_W-1:0] CTL_ADDR   = '1,
    parameter logic [RS_W-1:0]   STATUS_SEL = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_word,
    input  logic              rd_en,
    input  logic              conv_done,
    input  logic              cal_done,
    output logic              cfg_single,
    output logic [CH_W-1:0]   cfg_chan,
    output logic [PM_W-1:0]   cfg_pwr,
    output logic              if_mode,
    output logic              conv_go,
    output logic              cal_go,
    output logic [CS_W:0]     cal_type,
    output logic [CS_W-1:0]   coef_addr,
    output logic              coef_ok,
    output logic              busy,
    output logic [WORD_W-1:0] rd_data,
    output logic              rd_done
);
    ctl_t ctl;
    ctl_t pay;

    assign pay = ctl_t'(wr_word[PAY_W-1:0]);

    adcfg_ctl #(.AW(ADDR_W), .CTL_ADDR(CTL_ADDR)) u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_word[WORD_W-1 -: ADDR_W]),
        .wr_pay    (pay),
        .rd_en     (rd_en),
        .conv_done (conv_done),
        .cal_done  (cal_done),
        .ctl       (ctl),
        .conv_go   (conv_go),
        .cal_go    (cal_go)
    );

    adcfg_rdport #(.W(WORD_W), .STATUS_SEL(STATUS_SEL)) u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctl     (ctl),
        .rd_en   (rd_en),
        .rd_data (rd_data),
        .rd_done (rd_done)
    );

    assign cfg_single = ctl.single;
    assign cfg_chan   = ctl.chan;
    assign cfg_pwr    = ctl.pwr;
    assign if_mode    = ctl.mode;
    assign cal_type   = {ctl.calmd, ctl.csel};
    assign coef_addr  = ctl.csel;
    assign coef_ok    = !ctl.stcal;
    assign busy       = ctl.conv | ctl.stcal;

    AST_COEF_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        cal_go |-> !coef_ok); // R10
    AST_BUSY_ON_GO: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_go || cal_go) |-> busy); // R11
endmodule

// File: tb/sim_adcfg_regfile.sv
module sim_adcfg_regfile;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_word = '0;
    logic        rd_en = 1'b0;
    logic        conv_done = 1'b0;
    logic        cal_done = 1'b0;
    logic        cfg_single, if_mode, conv_go, cal_go, coef_ok, busy, rd_done;
    logic [2:0]  cfg_chan, cal_type;
    logic [1:0]  cfg_pwr, coef_addr;
    logic [15:0] rd_data;

    int errors = 0;
    int checks = 0;
    bit ended  = 1'b0;
    logic [13:0] m = '0;          // expected stored payload
    logic [15:0] expq[$];

    always #2 clk = ~clk;

    adcfg_regfile u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_word(wr_word), .rd_en(rd_en),
        .conv_done(conv_done), .cal_done(cal_done), .cfg_single(cfg_single),
        .cfg_chan(cfg_chan), .cfg_pwr(cfg_pwr), .if_mode(if_mode), .conv_go(conv_go),
        .cal_go(cal_go), .cal_type(cal_type), .coef_addr(coef_addr), .coef_ok(coef_ok),
        .busy(busy), .rd_data(rd_data), .rd_done(rd_done)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] stat(input logic [13:0] s);
        if (s[7:6] != 2'b11) return 16'h0000;
        return {1'b0, s[4] | s[0], s[13:5], 1'b0, s[3:0]};
    endfunction

    function automatic logic [13:0] pay(input logic sg, input logic [2:0] ch, input logic [1:0] pm,
                                        input logic [1:0] rs, input logic md, input logic cv,
                                        input logic cm, input logic [1:0] cs, input logic st);
        return {sg, ch, pm, rs, md, cv, cm, cs, st};
    endfunction

    // model update for a control write; returns expected {conv_go, cal_go}
    function automatic logic [1:0] apply(input logic [1:0] a, input logic [13:0] p);
        logic [1:0] g;
        g = 2'b00;
        if (a == 2'b11) begin
            g = {p[4] & ~m[4], p[0] & ~m[0]};
            m = {p[13:5], m[4] | p[4], p[3:1], m[0] | p[0]};
        end
        return g;
    endfunction

    task automatic cfg_chk(input string tag);
        chk({tag, " cfg"}, {cfg_single, cfg_chan, cfg_pwr, if_mode}, {m[13], m[12:10], m[9:8], m[5]});
        chk({tag, " busy"}, busy, m[4] | m[0]);
        chk({tag, " coef"}, {coef_addr, coef_ok}, {m[2:1], ~m[0]});
    endtask

    task automatic wr(input string tag, input logic [1:0] a, input logic [13:0] p);
        logic [1:0] g;
        @(negedge clk);
        wr_en = 1'b1; wr_word = {a, p};
        g = apply(a, p);
        @(negedge clk);
        wr_en = 1'b0;
        chk({tag, " go"}, {conv_go, cal_go}, g);
        cfg_chk(tag);
        @(negedge clk);
        chk({tag, " go drop"}, {conv_go, cal_go}, 2'b00);
    endtask

    task automatic rd(input string tag);
        @(negedge clk);
        rd_en = 1'b1;
        expq.push_back(stat(m));
        m[5] = 1'b0;
        @(negedge clk);
        rd_en = 1'b0;
        chk({tag, " R7 mode after read"}, if_mode, 1'b0);
    endtask

    task automatic done(input logic cv, input logic cl);
        @(negedge clk);
        conv_done = cv; cal_done = cl;
        if (cv) m[4] = 1'b0;
        if (cl) m[0] = 1'b0;
        @(negedge clk);
        conv_done = 1'b0; cal_done = 1'b0;
    endtask

    // monitor: scoreboard for read words (R8 timing, R3/R9 contents)
    always @(negedge clk) begin
        if (rst_n && rd_done) begin
            if (expq.size() == 0) chk("R8 unexpected rd_done", 16'h1, 16'h0);
            else chk("R3/R8/R9 read word", rd_data, expq.pop_front());
        end
    end

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(4 * 20000);
        errors++; checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R2 reset state
        chk("R2 reset read", {rd_data[15:1], rd_done}, 16'h0);
        chk("R2 reset pulses", {conv_go, cal_go}, 2'b00);
        cfg_chk("R2 reset");
        rst_n = 1'b1;

        // R1 wrong address ignored; R9 non-status read gives zero
        wr("R1 addr01", 2'b01, 14'h3FFF);
        wr("R1 addr10", 2'b10, 14'h3FFF);
        rd("R9 sel00");

        // R1/R3 full configuration, then status echo
        wr("R1 cfg", 2'b11, pay(1, 3'd5, 2'd2, 2'b11, 1, 0, 1, 2'd2, 0));
        rd("R3 status echo");
        rd("R7 second read");

        // R4 conversion start, R5 repeated start and cancel ignored
        wr("R4 conv start", 2'b11, pay(0, 3'd3, 2'd1, 2'b11, 1, 1, 0, 2'd1, 0));
        rd("R11 busy conv");
        wr("R5 restart", 2'b11, pay(0, 3'd3, 2'd1, 2'b11, 0, 1, 0, 2'd1, 0));
        wr("R5 no cancel", 2'b11, pay(0, 3'd4, 2'd1, 2'b11, 0, 0, 0, 2'd1, 0));
        done(1, 0);
        cfg_chk("R4 after done");
        rd("R11 idle");

        // R6 calibration start, R10 coefficient gating
        wr("R6 cal start", 2'b11, pay(1, 3'd7, 2'd0, 2'b11, 0, 0, 1, 2'd3, 1));
        chk("R6 cal_type", cal_type, 3'b111);
        rd("R6 status cal run");
        wr("R5 cal restart", 2'b11, pay(1, 3'd7, 2'd0, 2'b11, 0, 0, 0, 2'd1, 1));
        chk("R10 coef_addr follows", coef_addr, 2'd1);
        done(0, 1);
        cfg_chk("R6 after cal_done");
        rd("R6 cal ended");

        // R11 done strobes while idle change nothing
        done(1, 1);
        cfg_chk("R11 idle done");
        rd("R11 idle done read");

        // both engines at once
        wr("R11 both", 2'b11, pay(0, 3'd1, 2'd3, 2'b11, 1, 1, 0, 2'd0, 1));
        rd("R11 both busy");
        done(1, 0);
        rd("R11 cal only");
        done(0, 1);

        // R7 write and read in the same cycle: written mode kept
        wr("R7 pre", 2'b11, pay(0, 3'd2, 2'd0, 2'b11, 0, 0, 0, 2'd0, 0));
        @(negedge clk);
        rd_en = 1'b1; wr_en = 1'b1;
        wr_word = {2'b11, pay(0, 3'd6, 2'd0, 2'b11, 1, 0, 0, 2'd0, 0)};
        expq.push_back(stat(m));
        void'(apply(2'b11, wr_word[13:0]));
        @(negedge clk);
        rd_en = 1'b0; wr_en = 1'b0;
        chk("R7 write wins mode", if_mode, 1'b1);
        cfg_chk("R7 same cycle");

        // R9 read select not status
        wr("R9 sel01", 2'b11, pay(0, 3'd6, 2'd0, 2'b01, 0, 0, 0, 2'd0, 0));
        rd("R9 sel01 read");
        repeat (2) @(negedge clk);
        chk("R8 queue drained", expq.size(), 0);
        finish_run();
    end
endmodule